// File: doc/BRIEF.md
# Processor Bus Command Controller

This block turns the three-bit status code a processor places on its status lines into bus command strobes and data-transceiver controls, all timed on one clock. When the status leaves the passive code, the block latches it, pulses an address-latch strobe, and then drives the read or write commands that the latched code calls for. Each write also has an advanced form that asserts as early as a read. When the status returns to passive, the block releases every command.

A strapped mode input selects one of two bus arrangements. In shared-bus mode, every command waits for an arbiter's active-low address enable to have been low for a set number of clocks. The dual-purpose pin then acts as an active-high cascade enable on the second of each pair of interrupt acknowledge cycles. In dedicated-I/O mode, I/O commands and interrupt acknowledge ignore the arbiter, and the dual pin becomes an active-low enable for the peripheral transceiver. A command-enable qualifier can hold all commands and data enables inactive without releasing the drivers. Two output-enable flags stand in for the three-state drivers of the memory and I/O command groups.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: The latched status code selects the command set. 000 gives interrupt acknowledge. 001 gives I/O read. 010 gives I/O write plus advanced I/O write. 100 and 101 give memory read. 110 gives memory write plus advanced memory write. 011 (halt) and 111 (passive) give no command.
- R2: On the first rising edge at which the status input is 111, every command output goes high, the data enable goes low and the direction goes low.
- R3: On the edge that first sees a non-passive status, the address-latch strobe asserts. Read, advanced-write and acknowledge commands assert on the following edge. A normal write asserts one edge after its advanced write.
- R4: The address-latch strobe is high for exactly one clock per machine cycle. The status is latched on that edge, and later non-passive changes have no effect on the commands until the status returns to passive.
- R5: The direction output is high through write cycles (codes 010 and 110) from the strobe edge onward, and low otherwise. The data enable is active high and asserts with the read or advanced-write command.
- R6: With the command-enable input low at an edge, that edge drives every command high, the data enable low and the peripheral data enable high. The output-enable flags and the direction output are unchanged.
- R7: With the mode input high, I/O commands and acknowledge ignore address enable, and the I/O output-enable flag stays 1. The dual pin is driven low alongside I/O and acknowledge commands and high otherwise. The data enable serves only memory cycles.
- R8: A memory command, and in shared-bus mode any command, asserts only at an edge before which address enable was sampled low on the previous AEN_DLY edges.
- R9: Address enable high clears the memory output-enable flag at once, without waiting for a clock. In shared-bus mode it also clears the I/O output-enable flag.
- R10: In shared-bus mode, the dual pin is high from the strobe edge to the end of the second of two back-to-back acknowledge cycles, and low during the first. Any non-acknowledge cycle restarts the pairing.
- R11: While reset is high, all commands are high and the strobe, data enable, direction and cascade enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stat_i | input | 3 | Processor status code |
| aen_n_i | input | 1 | Active-low address enable from the arbiter |
| cen_i | input | 1 | Command-enable qualifier, active high |
| iob_i | input | 1 | Mode strap: 1 dedicated-I/O mode, 0 shared-bus mode |
| mrdc_n_o | output | 1 | Memory read command, active low |
| mwtc_n_o | output | 1 | Memory write command, active low |
| amwc_n_o | output | 1 | Advanced memory write command, active low |
| iorc_n_o | output | 1 | I/O read command, active low |
| iowc_n_o | output | 1 | I/O write command, active low |
| aiowc_n_o | output | 1 | Advanced I/O write command, active low |
| inta_n_o | output | 1 | Interrupt acknowledge command, active low |
| ale_o | output | 1 | Address-latch strobe |
| den_o | output | 1 | Data enable, active high |
| dt_r_o | output | 1 | Data direction: 1 transmit, 0 receive |
| mce_pden_o | output | 1 | Cascade enable (shared-bus mode, active high) or peripheral data enable (dedicated-I/O mode, active low) |
| mem_oe_o | output | 1 | Memory command group drivers enabled |
| io_oe_o | output | 1 | I/O command group drivers enabled |

## Verification
A corrupt latched code or phase counter appears one edge after the strobe as a wrong or missing command, or as a direction level that disagrees with the command. A stuck active flag shows as commands still held on the edge after the status returns to passive. An error in the acknowledge pairing flag is visible at the strobe edge of the next acknowledge cycle, when the cascade enable is high where it should be masked. A wrong address-enable counter moves the first memory command earlier or later by whole clocks from the expected AEN_DLY+1 edges.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    ST_ACK   = 3'b000,
    ST_IORD  = 3'b001,
    ST_IOWR  = 3'b010,
    ST_HALT  = 3'b011,
    ST_FETCH = 3'b100,
    ST_MRD   = 3'b101,
    ST_MWR   = 3'b110,
    ST_IDLE  = 3'b111
  } stat_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic ack;
    logic is_wr;
  } kind_t;

  localparam int PH_W = 2;
  localparam logic [PH_W-1:0] PH_LATE = 2'd2;

  function automatic kind_t decode_kind(input logic [2:0] s);
    kind_t k;
    k = '0;
    case (stat_e'(s))
      ST_ACK:           k.ack = 1'b1;
      ST_IORD:          k.io_rd = 1'b1;
      ST_IOWR:          begin k.io_wr = 1'b1; k.is_wr = 1'b1; end
      ST_FETCH, ST_MRD: k.mem_rd = 1'b1;
      ST_MWR:           begin k.mem_wr = 1'b1; k.is_wr = 1'b1; end
      default:          k = '0;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/bcc_aen_timer.sv
module bcc_aen_timer #(
  parameter int AEN_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic aen_n_i,
  output logic aen_ok_o
);

  generate
    if (AEN_DLY == 0) begin : g_nodly
      logic unused_clk_rst;
      assign unused_clk_rst = clk | rst;
      assign aen_ok_o = ~aen_n_i;
    end else begin : g_cnt
      localparam int CW = $clog2(AEN_DLY + 1);
      localparam logic [CW-1:0] LIM = CW'(AEN_DLY);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || aen_n_i) begin
          cnt_q <= '0;
        end else if (cnt_q != LIM) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign aen_ok_o = (cnt_q == LIM);
    end
  endgenerate

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      stat_i,
  output logic            act_nx_o,
  output logic [PH_W-1:0] ph_nx_o,
  output logic [2:0]      code_nx_o,
  output logic            start_nx_o,
  output logic            second_nx_o
);

  logic            act_q, pend_q, second_q;
  logic [PH_W-1:0] ph_q;
  logic [2:0]      code_q;
  logic            pend_nx;
  logic            passive;

  assign passive    = (stat_i == ST_IDLE);
  assign start_nx_o = ~act_q & ~passive;

  always_comb begin
    act_nx_o    = act_q;
    ph_nx_o     = ph_q;
    code_nx_o   = code_q;
    second_nx_o = second_q;
    pend_nx     = pend_q;
    if (passive) begin
      act_nx_o = 1'b0;
      ph_nx_o  = '0;
    end else if (!act_q) begin
      act_nx_o    = 1'b1;
      ph_nx_o     = '0;
      code_nx_o   = stat_i;
      second_nx_o = (stat_i == ST_ACK) & pend_q;
      pend_nx     = (stat_i == ST_ACK) & ~pend_q;
    end else if (ph_q != PH_LATE) begin
      ph_nx_o = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      ph_q     <= '0;
      code_q   <= ST_IDLE;
      pend_q   <= 1'b0;
      second_q <= 1'b0;
    end else begin
      act_q    <= act_nx_o;
      ph_q     <= ph_nx_o;
      code_q   <= code_nx_o;
      pend_q   <= pend_nx;
      second_q <= second_nx_o;
    end
  end

endmodule

// File: rtl/bcc_drive.sv
module bcc_drive
  import bcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cen_i,
  input  logic            iob_i,
  input  logic            aen_ok_i,
  input  logic            act_nx_i,
  input  logic [PH_W-1:0] ph_nx_i,
  input  logic [2:0]      code_nx_i,
  input  logic            start_nx_i,
  input  logic            second_nx_i,
  output logic            mrdc_n_o,
  output logic            mwtc_n_o,
  output logic            amwc_n_o,
  output logic            iorc_n_o,
  output logic            iowc_n_o,
  output logic            aiowc_n_o,
  output logic            inta_n_o,
  output logic            ale_o,
  output logic            den_o,
  output logic            dt_r_o,
  output logic            mp_act_o
);

  kind_t k;
  logic  en, early, late, mem_g, io_g, io_kind, mem_kind;

  assign k        = decode_kind(code_nx_i);
  assign en       = act_nx_i & cen_i;
  assign early    = en & (ph_nx_i != '0);
  assign late     = en & (ph_nx_i == PH_LATE);
  assign mem_g    = aen_ok_i;
  assign io_g     = iob_i | aen_ok_i;
  assign io_kind  = k.io_rd | k.io_wr | k.ack;
  assign mem_kind = k.mem_rd | k.mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mrdc_n_o  <= 1'b1;
      mwtc_n_o  <= 1'b1;
      amwc_n_o  <= 1'b1;
      iorc_n_o  <= 1'b1;
      iowc_n_o  <= 1'b1;
      aiowc_n_o <= 1'b1;
      inta_n_o  <= 1'b1;
      ale_o     <= 1'b0;
      den_o     <= 1'b0;
      dt_r_o    <= 1'b0;
      mp_act_o  <= 1'b0;
    end else begin
      mrdc_n_o  <= ~(early & mem_g & k.mem_rd);
      amwc_n_o  <= ~(early & mem_g & k.mem_wr);
      mwtc_n_o  <= ~(late & mem_g & k.mem_wr & ~amwc_n_o);
      iorc_n_o  <= ~(early & io_g & k.io_rd);
      aiowc_n_o <= ~(early & io_g & k.io_wr);
      iowc_n_o  <= ~(late & io_g & k.io_wr & ~aiowc_n_o);
      inta_n_o  <= ~(early & io_g & k.ack);
      ale_o     <= start_nx_i;
      dt_r_o    <= act_nx_i & k.is_wr;
      den_o     <= early & ((mem_g & mem_kind) | (~iob_i & io_g & io_kind));
      mp_act_o  <= iob_i ? (early & io_kind) : (act_nx_i & k.ack & second_nx_i);
    end
  end

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
#(
  parameter int AEN_DLY = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] stat_i,
  input  logic       aen_n_i,
  input  logic       cen_i,
  input  logic       iob_i,
  output logic       mrdc_n_o,
  output logic       mwtc_n_o,
  output logic       amwc_n_o,
  output logic       iorc_n_o,
  output logic       iowc_n_o,
  output logic       aiowc_n_o,
  output logic       inta_n_o,
  output logic       ale_o,
  output logic       den_o,
  output logic       dt_r_o,
  output logic       mce_pden_o,
  output logic       mem_oe_o,
  output logic       io_oe_o
);

  logic            aen_ok;
  logic            act_nx, start_nx, second_nx, mp_act;
  logic [PH_W-1:0] ph_nx;
  logic [2:0]      code_nx;

  bcc_aen_timer #(.AEN_DLY(AEN_DLY)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .aen_n_i  (aen_n_i),
    .aen_ok_o (aen_ok)
  );

  bcc_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .stat_i      (stat_i),
    .act_nx_o    (act_nx),
    .ph_nx_o     (ph_nx),
    .code_nx_o   (code_nx),
    .start_nx_o  (start_nx),
    .second_nx_o (second_nx)
  );

  bcc_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .cen_i       (cen_i),
    .iob_i       (iob_i),
    .aen_ok_i    (aen_ok),
    .act_nx_i    (act_nx),
    .ph_nx_i     (ph_nx),
    .code_nx_i   (code_nx),
    .start_nx_i  (start_nx),
    .second_nx_i (second_nx),
    .mrdc_n_o    (mrdc_n_o),
    .mwtc_n_o    (mwtc_n_o),
    .amwc_n_o    (amwc_n_o),
    .iorc_n_o    (iorc_n_o),
    .iowc_n_o    (iowc_n_o),
    .aiowc_n_o   (aiowc_n_o),
    .inta_n_o    (inta_n_o),
    .ale_o       (ale_o),
    .den_o       (den_o),
    .dt_r_o      (dt_r_o),
    .mp_act_o    (mp_act)
  );

  // Dual pin polarity follows the mode strap; driver enables track the arbiter at once.
  assign mce_pden_o = iob_i ? ~mp_act : mp_act;
  assign mem_oe_o   = ~aen_n_i;
  assign io_oe_o    = iob_i | ~aen_n_i;

endmodule

// File: rtl/bcc_chk.sv
module bcc_chk #(
  parameter int AEN_DLY = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] stat_i,
  input logic       aen_n_i,
  input logic       cen_i,
  input logic       iob_i,
  input logic       mrdc_n_o,
  input logic       mwtc_n_o,
  input logic       amwc_n_o,
  input logic       iorc_n_o,
  input logic       iowc_n_o,
  input logic       aiowc_n_o,
  input logic       inta_n_o,
  input logic       ale_o,
  input logic       den_o,
  input logic       dt_r_o,
  input logic       mce_pden_o
);

  int low_run;
  always_ff @(posedge clk) begin
    if (rst || aen_n_i) low_run <= 0;
    else if (low_run < AEN_DLY) low_run <= low_run + 1;
  end

  logic all_idle;
  assign all_idle = mrdc_n_o & mwtc_n_o & amwc_n_o & iorc_n_o & iowc_n_o & aiowc_n_o & inta_n_o;

  assert_one_kind_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~mrdc_n_o, ~amwc_n_o, ~iorc_n_o, ~aiowc_n_o, ~inta_n_o}));

  assert_passive_release_R2: assert property (@(posedge clk) disable iff (rst)
    (stat_i == 3'b111) |=> (all_idle && !den_o && !dt_r_o));

  assert_mwr_after_adv_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mwtc_n_o) |-> $past(!amwc_n_o));

  assert_iowr_after_adv_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(iowc_n_o) |-> $past(!aiowc_n_o));

  assert_ale_single_R4: assert property (@(posedge clk) disable iff (rst)
    ale_o |=> !ale_o);

  assert_dir_read_R5: assert property (@(posedge clk) disable iff (rst)
    (!mrdc_n_o || !iorc_n_o || !inta_n_o) |-> !dt_r_o);

  assert_dir_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!amwc_n_o || !aiowc_n_o) |-> dt_r_o);

  assert_cen_block_R6: assert property (@(posedge clk) disable iff (rst)
    !cen_i |=> (all_idle && !den_o));

  assert_aen_wait_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(mrdc_n_o) |-> ($past(low_run) >= AEN_DLY));

  assert_mce_no_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    (!iob_i && mce_pden_o) |-> (mrdc_n_o && amwc_n_o && iorc_n_o && aiowc_n_o));

endmodule

bind bus_cmd_ctrl bcc_chk #(.AEN_DLY(AEN_DLY)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stat_i     (stat_i),
  .aen_n_i    (aen_n_i),
  .cen_i      (cen_i),
  .iob_i      (iob_i),
  .mrdc_n_o   (mrdc_n_o),
  .mwtc_n_o   (mwtc_n_o),
  .amwc_n_o   (amwc_n_o),
  .iorc_n_o   (iorc_n_o),
  .iowc_n_o   (iowc_n_o),
  .aiowc_n_o  (aiowc_n_o),
  .inta_n_o   (inta_n_o),
  .ale_o      (ale_o),
  .den_o      (den_o),
  .dt_r_o     (dt_r_o),
  .mce_pden_o (mce_pden_o)
);

// File: tb/tb_bus_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_bus_cmd_ctrl;

  localparam int AEN_DLY = 2;

  localparam logic [12:0] B_MRD  = 13'h1000;
  localparam logic [12:0] B_MWT  = 13'h0800;
  localparam logic [12:0] B_AMW  = 13'h0400;
  localparam logic [12:0] B_IORD = 13'h0200;
  localparam logic [12:0] B_IOWR = 13'h0100;
  localparam logic [12:0] B_AIOW = 13'h0080;
  localparam logic [12:0] B_ACK  = 13'h0040;
  localparam logic [12:0] B_ALE  = 13'h0020;
  localparam logic [12:0] B_DEN  = 13'h0010;
  localparam logic [12:0] B_DTR  = 13'h0008;
  localparam logic [12:0] B_MP   = 13'h0004;
  localparam logic [12:0] B_MOE  = 13'h0002;
  localparam logic [12:0] B_IOE  = 13'h0001;
  localparam logic [12:0] OE     = B_MOE | B_IOE;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] stat = 3'b111;
  logic       aen_n = 1'b1;
  logic       cen = 1'b1;
  logic       iob = 1'b0;
  logic mrdc_n, mwtc_n, amwc_n, iorc_n, iowc_n, aiowc_n, inta_n;
  logic ale, den, dt_r, mce_pden, mem_oe, io_oe;

  bus_cmd_ctrl #(.AEN_DLY(AEN_DLY)) dut (
    .clk(clk), .rst(rst), .stat_i(stat), .aen_n_i(aen_n), .cen_i(cen), .iob_i(iob),
    .mrdc_n_o(mrdc_n), .mwtc_n_o(mwtc_n), .amwc_n_o(amwc_n), .iorc_n_o(iorc_n),
    .iowc_n_o(iowc_n), .aiowc_n_o(aiowc_n), .inta_n_o(inta_n), .ale_o(ale),
    .den_o(den), .dt_r_o(dt_r), .mce_pden_o(mce_pden), .mem_oe_o(mem_oe), .io_oe_o(io_oe)
  );

  always #5 clk = ~clk;

  logic [12:0] obs;
  assign obs = {~mrdc_n, ~mwtc_n, ~amwc_n, ~iorc_n, ~iowc_n, ~aiowc_n, ~inta_n,
                ale, den, dt_r, mce_pden, mem_oe, io_oe};

  typedef struct {
    int          cyc;
    logic [12:0] v;
    string       req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;

  task automatic push(input int c, input logic [12:0] v, input string req);
    item_t it;
    it.cyc = c; it.v = v; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: pops expectations due this cycle and compares against the ports.
  always begin
    @(posedge clk);
    cyc++;
    #2;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.cyc != cyc || obs !== it.v) begin
        n_err++;
        $display("FAIL %s cyc %0d actual %h expected %h", it.req, cyc, obs, it.v);
      end
    end
  end

  task automatic run(input logic [2:0] code, input int len,
                     input logic [12:0] e0, input logic [12:0] e1, input logic [12:0] e2,
                     input logic [12:0] idle, input string req);
    int c;
    @(negedge clk);
    c = cyc;
    stat = code;
    push(c + 1, e0, req);
    push(c + 2, e1, req);
    for (int i = 3; i <= len; i++) push(c + i, e2, req);
    repeat (len) @(negedge clk);
    stat = 3'b111;
    push(c + len + 1, idle, {req, " release"});
    push(c + len + 2, idle, {req, " idle"});
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int c;
    // R11: reset state
    push(2, 13'h0000, "R11 reset");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    aen_n = 1'b0;
    repeat (4) @(negedge clk);

    // R1 R3 R5: shared-bus mode, arbiter granted
    run(3'b101, 4, B_ALE|OE, B_MRD|B_DEN|OE, B_MRD|B_DEN|OE, OE, "R1 mem read");
    run(3'b100, 3, B_ALE|OE, B_MRD|B_DEN|OE, B_MRD|B_DEN|OE, OE, "R1 code fetch");
    run(3'b110, 4, B_ALE|B_DTR|OE, B_AMW|B_DEN|B_DTR|OE,
        B_AMW|B_MWT|B_DEN|B_DTR|OE, OE, "R3 R5 mem write");
    run(3'b001, 3, B_ALE|OE, B_IORD|B_DEN|OE, B_IORD|B_DEN|OE, OE, "R1 io read");
    run(3'b010, 4, B_ALE|B_DTR|OE, B_AIOW|B_DEN|B_DTR|OE,
        B_AIOW|B_IOWR|B_DEN|B_DTR|OE, OE, "R3 R5 io write");
    run(3'b011, 3, B_ALE|OE, OE, OE, OE, "R1 R4 halt");

    // R10: acknowledge pairing
    run(3'b000, 3, B_ALE|OE, B_ACK|B_DEN|OE, B_ACK|B_DEN|OE, OE, "R10 first ack masked");
    run(3'b000, 3, B_ALE|B_MP|OE, B_ACK|B_DEN|B_MP|OE, B_ACK|B_DEN|B_MP|OE, OE, "R10 second ack cascade");
    run(3'b000, 3, B_ALE|OE, B_ACK|B_DEN|OE, B_ACK|B_DEN|OE, OE, "R10 new pair masked");
    run(3'b101, 3, B_ALE|OE, B_MRD|B_DEN|OE, B_MRD|B_DEN|OE, OE, "R10 intervening read");
    run(3'b000, 3, B_ALE|OE, B_ACK|B_DEN|OE, B_ACK|B_DEN|OE, OE, "R10 pair restarted");

    // R4: status change mid-cycle is ignored
    @(negedge clk); c = cyc; stat = 3'b101;
    push(c+1, B_ALE|OE, "R4 latch"); push(c+2, B_MRD|B_DEN|OE, "R4 latch");
    @(negedge clk); @(negedge clk); stat = 3'b110;
    push(c+3, B_MRD|B_DEN|OE, "R4 ignore change"); push(c+4, B_MRD|B_DEN|OE, "R4 ignore change");
    @(negedge clk); @(negedge clk); stat = 3'b111;
    push(c+5, OE, "R2 release after change");
    repeat (2) @(negedge clk);

    // R6: command enable low for a whole cycle, then mid-cycle
    cen = 1'b0;
    run(3'b101, 3, B_ALE|OE, OE, OE, OE, "R6 read blocked");
    run(3'b110, 3, B_ALE|B_DTR|OE, B_DTR|OE, B_DTR|OE, OE, "R6 write blocked dir kept");
    cen = 1'b1;
    @(negedge clk); c = cyc; stat = 3'b110;
    push(c+1, B_ALE|B_DTR|OE, "R6 pre"); push(c+2, B_AMW|B_DEN|B_DTR|OE, "R6 pre");
    push(c+3, B_AMW|B_MWT|B_DEN|B_DTR|OE, "R6 pre");
    repeat (3) @(negedge clk); cen = 1'b0;
    push(c+4, B_DTR|OE, "R6 mid-cycle drop"); push(c+5, B_DTR|OE, "R6 mid-cycle drop");
    repeat (2) @(negedge clk); stat = 3'b111;
    push(c+6, OE, "R2 release");
    @(negedge clk); cen = 1'b1;
    repeat (2) @(negedge clk);

    // R9: arbiter releases the bus in shared-bus mode
    @(negedge clk); c = cyc; aen_n = 1'b1;
    #1;
    n_chk++;
    if (mem_oe !== 1'b0 || io_oe !== 1'b0) begin
      n_err++;
      $display("FAIL R9 immediate release actual %b%b expected 00", mem_oe, io_oe);
    end
    push(c+1, 13'h0000, "R9 drivers off");
    repeat (3) @(negedge clk);

    // R8: command waits for address enable
    c = cyc; stat = 3'b101; aen_n = 1'b0;
    push(c+1, B_ALE|OE, "R8 wait"); push(c+2, OE, "R8 wait");
    push(c+3, B_MRD|B_DEN|OE, "R8 read after delay"); push(c+4, B_MRD|B_DEN|OE, "R8 hold");
    repeat (4) @(negedge clk); stat = 3'b111; aen_n = 1'b1;
    push(c+5, 13'h0000, "R8 release");
    repeat (3) @(negedge clk);
    c = cyc; stat = 3'b110; aen_n = 1'b0;
    push(c+1, B_ALE|B_DTR|OE, "R8 write wait"); push(c+2, B_DTR|OE, "R8 write wait");
    push(c+3, B_AMW|B_DEN|B_DTR|OE, "R8 R3 adv after delay");
    push(c+4, B_AMW|B_MWT|B_DEN|B_DTR|OE, "R3 write one later");
    repeat (4) @(negedge clk); stat = 3'b111;
    push(c+5, OE, "R2 release");
    repeat (2) @(negedge clk);

    // R7: dedicated-I/O mode with the arbiter not granting
    aen_n = 1'b1; iob = 1'b1;
    repeat (3) @(negedge clk);
    run(3'b001, 3, B_ALE|B_MP|B_IOE, B_IORD|B_IOE, B_IORD|B_IOE, B_MP|B_IOE, "R7 io read no aen");
    run(3'b010, 4, B_ALE|B_DTR|B_MP|B_IOE, B_AIOW|B_DTR|B_IOE,
        B_AIOW|B_IOWR|B_DTR|B_IOE, B_MP|B_IOE, "R7 io write no aen");
    run(3'b000, 3, B_ALE|B_MP|B_IOE, B_ACK|B_IOE, B_ACK|B_IOE, B_MP|B_IOE, "R7 ack no aen");
    run(3'b101, 3, B_ALE|B_MP|B_IOE, B_MP|B_IOE, B_MP|B_IOE, B_MP|B_IOE, "R7 R8 mem read blocked");
    cen = 1'b0;
    run(3'b001, 3, B_ALE|B_MP|B_IOE, B_MP|B_IOE, B_MP|B_IOE, B_MP|B_IOE, "R6 R7 pden held");
    cen = 1'b1;
    aen_n = 1'b0;
    repeat (4) @(negedge clk);
    run(3'b101, 3, B_ALE|B_MP|OE, B_MRD|B_DEN|B_MP|OE, B_MRD|B_DEN|B_MP|OE, B_MP|OE, "R7 mem read den");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule